// File: doc/BRIEF.md
# Configuration Port Bridge

This block sits between a simple 32-bit register bus and a device configuration engine. A host loads configuration words one at a time into a write queue, checks the free-space register so that it never overruns the queue, and then sets a self-clearing control bit that streams the queued words out to the engine over a valid/ready handshake. The host polls that bit, or the status register, or waits for the write-done interrupt, to learn when every queued word has left.

For readback, the host stores a word count in a size register and sets a second self-clearing control bit. The bridge then accepts that many words from the engine's source port into a read queue. The host reads the occupancy register and pops the words one per bus read. Interrupt status, a per-source enable and a global enable gate a single interrupt line. A sticky abort flag records any word that was pushed while the write queue was full.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset the vacancy register (offset 69) reads 64, the read occupancy (offset 70) reads 0, control (offset 67) reads 0, interrupt status (offset 8) reads 0 and `irq` is low.
- R2: Each bus write to offset 64 queues one 32-bit word. Queued words leave on `cp_wdata` unchanged and in the order written. Offset 69 reads 64 minus the number of words queued and not yet sent.
- R3: Writing 1 to control bit 0 starts the drain. Bit 0 reads 1 until the write queue is empty, and then clears by itself.
- R4: The drain presents one word per clock on `cp_wvalid`/`cp_wdata`. While `cp_wready` is low, it holds the same word and sends nothing.
- R5: Writing 1 to control bit 1 requests as many words as the size register (offset 66, low 16 bits, read/write) holds. Bit 1 reads 1 until that many words have been accepted. Accepted words enter the read queue in arrival order, and offset 70 counts them.
- R6: Each bus read of offset 65 returns the oldest word in the read queue and removes it. A read of offset 65 while the queue is empty returns 0.
- R7: Status (offset 68) bit 0 is 1 when neither transfer is active. Bit 2 is 1 when, in addition, the write queue is empty.
- R8: A write to offset 64 while the write queue is full is dropped and sets abort-status (offset 71) bit 0. That bit stays set until 1 is written to it.
- R9: Interrupt status bit 0 is set in the cycle the drain completes, and bit 1 is set in the cycle a readback completes. Writing 1 to a bit clears it.
- R10: `irq` is high exactly when global enable (offset 7, bit 0) is set and some interrupt status bit is set together with its enable bit (offset 10, bits 1:0).
- R11: Reads of offsets not listed return 0, and writes to them change nothing.
- R12: When the read queue holds 64 words, `cp_rready` is low. The readback resumes once the host pops words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is returned after the next edge |
| reg_addr | input | 7 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| cp_wvalid | output | 1 | Word valid toward the configuration engine |
| cp_wdata | output | 32 | Word toward the configuration engine |
| cp_wready | input | 1 | Engine accepts the word |
| cp_rvalid | input | 1 | Readback word valid from the engine |
| cp_rdata | input | 32 | Readback word from the engine |
| cp_rready | output | 1 | Bridge accepts a readback word |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume the engine keeps to its side of the handshake, so that `cp_rdata` is meaningful only while `cp_rvalid` is high. The bench drives one bus access at a time, through tasks that raise a single strobe. It varies `cp_wready` and `cp_rvalid` from a seeded generator, which exercises stalls without breaking either rule. Overflow and a full read queue are reached on purpose: the engine is held not ready, or the requested size is larger than the read queue.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  // Word offsets of the register map
  localparam int OFS_GIE   = 7;
  localparam int OFS_ISR   = 8;
  localparam int OFS_IER   = 10;
  localparam int OFS_WPUSH = 64;
  localparam int OFS_RPOP  = 65;
  localparam int OFS_SIZE  = 66;
  localparam int OFS_CTRL  = 67;
  localparam int OFS_STAT  = 68;
  localparam int OFS_WVAC  = 69;
  localparam int OFS_ROCC  = 70;
  localparam int OFS_ABRT  = 71;

  // Event pair shared by control, interrupt status and enable
  typedef struct packed {
    logic rd;
    logic wr;
  } cfgb_evt_t;
endpackage

// File: rtl/cfgb_fifo.sv
module cfgb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = do_push ? bump(wp_q) : wp_q;
    rp_d  = do_pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic          start_rd,
  input  logic [SW-1:0] rb_size,
  input  logic          wf_empty,
  input  logic [DW-1:0] wf_head,
  output logic          wf_pop,
  input  logic          cp_wready,
  output logic          cp_wvalid,
  output logic [DW-1:0] cp_wdata,
  input  logic          rf_full,
  output logic          rf_push,
  output logic [DW-1:0] rf_wdata,
  input  logic          cp_rvalid,
  input  logic [DW-1:0] cp_rdata,
  output logic          cp_rready,
  output logic          wr_busy,
  output logic          rd_busy,
  output logic          wr_done,
  output logic          rd_done
);
  logic          wbusy_q, wbusy_d;
  logic          rbusy_q, rbusy_d;
  logic [SW-1:0] left_q, left_d;

  // Drain side: show the queue head while active, advance on handshake
  assign cp_wvalid = wbusy_q && !wf_empty;
  assign cp_wdata  = wf_head;
  assign wf_pop    = cp_wvalid && cp_wready;

  // Readback side: accept only while words remain and there is room
  assign cp_rready = rbusy_q && (left_q != '0) && !rf_full;
  assign rf_push   = cp_rvalid && cp_rready;
  assign rf_wdata  = cp_rdata;

  always_comb begin
    wbusy_d = wbusy_q;
    wr_done = 1'b0;
    if (wbusy_q) begin
      if (wf_empty) begin
        wbusy_d = 1'b0;
        wr_done = 1'b1;
      end
    end else if (start_wr) begin
      wbusy_d = 1'b1;
    end
  end

  always_comb begin
    rbusy_d = rbusy_q;
    left_d  = left_q;
    rd_done = 1'b0;
    if (rbusy_q) begin
      if (left_q == '0) begin
        rbusy_d = 1'b0;
        rd_done = 1'b1;
      end else if (rf_push) begin
        left_d = left_q - 1'b1;
      end
    end else if (start_rd) begin
      rbusy_d = 1'b1;
      left_d  = rb_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbusy_q <= 1'b0;
      rbusy_q <= 1'b0;
      left_q  <= '0;
    end else begin
      wbusy_q <= wbusy_d;
      rbusy_q <= rbusy_d;
      left_q  <= left_d;
    end
  end

  assign wr_busy = wbusy_q;
  assign rd_busy = rbusy_q;
endmodule

// File: rtl/cfgb_regs.sv
module cfgb_regs
  import cfgb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 7,
  parameter int SW     = 16,
  parameter int WDEPTH = 64,
  parameter int WCW    = 7,
  parameter int RCW    = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq,
  input  logic [WCW-1:0] wf_count,
  input  logic           wf_full,
  input  logic           wf_empty,
  output logic           wf_push,
  input  logic [RCW-1:0] rf_count,
  input  logic           rf_empty,
  input  logic [DW-1:0]  rf_head,
  output logic           rf_pop,
  input  logic           wr_busy,
  input  logic           rd_busy,
  input  logic           wr_done,
  input  logic           rd_done,
  output logic           start_wr,
  output logic           start_rd,
  output logic [SW-1:0]  rb_size
);
  logic          gie_q, gie_d;
  cfgb_evt_t     isr_q, isr_d, ier_q, ier_d, w1c;
  logic [SW-1:0] size_q, size_d;
  logic          ovf_q, ovf_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          idle;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  assign wf_push  = reg_wr && hit(reg_addr, OFS_WPUSH);
  assign rf_pop   = reg_rd && hit(reg_addr, OFS_RPOP);
  assign start_wr = reg_wr && hit(reg_addr, OFS_CTRL) && reg_wdata[0] && !wr_busy;
  assign start_rd = reg_wr && hit(reg_addr, OFS_CTRL) && reg_wdata[1] && !rd_busy;
  assign rb_size  = size_q;
  assign idle     = !wr_busy && !rd_busy;

  // Next state of the writable registers
  always_comb begin
    gie_d  = gie_q;
    ier_d  = ier_q;
    size_d = size_q;
    w1c    = '0;
    if (reg_wr) begin
      if (hit(reg_addr, OFS_GIE))  gie_d  = reg_wdata[0];
      if (hit(reg_addr, OFS_IER))  ier_d  = reg_wdata[1:0];
      if (hit(reg_addr, OFS_SIZE)) size_d = reg_wdata[SW-1:0];
      if (hit(reg_addr, OFS_ISR))  w1c    = reg_wdata[1:0];
    end
    // A completing event wins over a clear in the same cycle
    isr_d.wr = (isr_q.wr && !w1c.wr) || wr_done;
    isr_d.rd = (isr_q.rd && !w1c.rd) || rd_done;
    ovf_d = (ovf_q && !(reg_wr && hit(reg_addr, OFS_ABRT) && reg_wdata[0]))
            || (wf_push && wf_full);
  end

  // Read multiplexer; the pop offset returns 0 when the read queue is empty
  always_comb begin
    rdata_d = '0;
    unique case (reg_addr)
      AW'(OFS_GIE):  rdata_d = DW'(gie_q);
      AW'(OFS_ISR):  rdata_d = DW'(isr_q);
      AW'(OFS_IER):  rdata_d = DW'(ier_q);
      AW'(OFS_RPOP): rdata_d = rf_empty ? '0 : rf_head;
      AW'(OFS_SIZE): rdata_d = DW'(size_q);
      AW'(OFS_CTRL): rdata_d = DW'({rd_busy, wr_busy});
      AW'(OFS_STAT): rdata_d = DW'({idle && wf_empty, 1'b0, idle});
      AW'(OFS_WVAC): rdata_d = DW'(WDEPTH) - DW'(wf_count);
      AW'(OFS_ROCC): rdata_d = DW'(rf_count);
      AW'(OFS_ABRT): rdata_d = DW'(ovf_q);
      default:       rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      ier_q   <= '0;
      isr_q   <= '0;
      size_q  <= '0;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      gie_q  <= gie_d;
      ier_q  <= ier_d;
      isr_q  <= isr_d;
      size_q <= size_d;
      ovf_q  <= ovf_d;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = gie_q && |(isr_q & ier_q);
endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge #(
  parameter int DW     = 32,
  parameter int ADDR_W = 7,
  parameter int SIZE_W = 16,
  parameter int WDEPTH = 64,
  parameter int RDEPTH = 64,
  localparam int WCW   = $clog2(WDEPTH) + 1,
  localparam int RCW   = $clog2(RDEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              cp_wvalid,
  output logic [DW-1:0]     cp_wdata,
  input  logic              cp_wready,
  input  logic              cp_rvalid,
  input  logic [DW-1:0]     cp_rdata,
  output logic              cp_rready
);
  logic              wf_push, wf_pop, wf_full, wf_empty;
  logic [DW-1:0]     wf_head;
  logic [WCW-1:0]    wf_count;
  logic              rf_push, rf_pop, rf_full, rf_empty;
  logic [DW-1:0]     rf_head, rf_wdata;
  logic [RCW-1:0]    rf_count;
  logic              wr_busy, rd_busy, wr_done, rd_done;
  logic              start_wr, start_rd;
  logic [SIZE_W-1:0] rb_size;

  cfgb_regs #(
    .DW(DW), .AW(ADDR_W), .SW(SIZE_W), .WDEPTH(WDEPTH), .WCW(WCW), .RCW(RCW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .wf_count(wf_count), .wf_full(wf_full), .wf_empty(wf_empty), .wf_push(wf_push),
    .rf_count(rf_count), .rf_empty(rf_empty), .rf_head(rf_head), .rf_pop(rf_pop),
    .wr_busy(wr_busy), .rd_busy(rd_busy), .wr_done(wr_done), .rd_done(rd_done),
    .start_wr(start_wr), .start_rd(start_rd), .rb_size(rb_size)
  );

  cfgb_fifo #(.DW(DW), .DEPTH(WDEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n),
    .push(wf_push), .wdata(reg_wdata), .pop(wf_pop),
    .head(wf_head), .count(wf_count), .full(wf_full), .empty(wf_empty)
  );

  cfgb_fifo #(.DW(DW), .DEPTH(RDEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n),
    .push(rf_push), .wdata(rf_wdata), .pop(rf_pop),
    .head(rf_head), .count(rf_count), .full(rf_full), .empty(rf_empty)
  );

  cfgb_seq #(.DW(DW), .SW(SIZE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_rd(start_rd), .rb_size(rb_size),
    .wf_empty(wf_empty), .wf_head(wf_head), .wf_pop(wf_pop),
    .cp_wready(cp_wready), .cp_wvalid(cp_wvalid), .cp_wdata(cp_wdata),
    .rf_full(rf_full), .rf_push(rf_push), .rf_wdata(rf_wdata),
    .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata), .cp_rready(cp_rready),
    .wr_busy(wr_busy), .rd_busy(rd_busy), .wr_done(wr_done), .rd_done(rd_done)
  );
endmodule

// File: rtl/cfgb_chk.sv
module cfgb_chk #(
  parameter int DW     = 32,
  parameter int ADDR_W = 7,
  parameter int WDEPTH = 64,
  parameter int RDEPTH = 64,
  parameter int WCW    = 7,
  parameter int RCW    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              cp_wvalid,
  input logic [DW-1:0]     cp_wdata,
  input logic              cp_wready,
  input logic              cp_rvalid,
  input logic              cp_rready,
  input logic [WCW-1:0]    wf_count,
  input logic [RCW-1:0]    rf_count,
  input logic              wr_busy
);
  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_wvalid && !cp_wready |=> cp_wvalid && $stable(cp_wdata));

  // R3
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy && (wf_count == '0) |=> !wr_busy);

  // R2
  wcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wf_count <= WCW'(WDEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == ADDR_W'(64)) && (wf_count == WCW'(WDEPTH))
      && !(cp_wvalid && cp_wready) |=> wf_count == WCW'(WDEPTH));

  // R12
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_count == RCW'(RDEPTH)) |-> !cp_rready);

  // R5
  rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rvalid && cp_rready && !(reg_rd && reg_addr == ADDR_W'(65))
      |=> rf_count == $past(rf_count) + 1'b1);
endmodule

bind cfgport_bridge cfgb_chk #(
  .DW(DW), .ADDR_W(ADDR_W), .WDEPTH(WDEPTH), .RDEPTH(RDEPTH), .WCW(WCW), .RCW(RCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .cp_wvalid(cp_wvalid), .cp_wdata(cp_wdata), .cp_wready(cp_wready),
  .cp_rvalid(cp_rvalid), .cp_rready(cp_rready),
  .wf_count(wf_count), .rf_count(rf_count), .wr_busy(wr_busy)
);

// File: tb/tb_cfgport_bridge.sv
module tb_cfgport_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk, rst_n, reg_wr, reg_rd;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, cp_wdata, cp_rdata;
  logic        irq, cp_wvalid, cp_wready, cp_rvalid, cp_rready;

  cfgport_bridge dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cp_wvalid(cp_wvalid), .cp_wdata(cp_wdata), .cp_wready(cp_wready),
    .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata), .cp_rready(cp_rready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int wmode = 0, rmode = 0;   // 0 always, 1 random, 2 never
  logic [31:0] exp_mem [0:511];
  logic [31:0] sink_mem [0:511];
  int exp_n = 0, sink_n = 0, src_idx = 0, pop_idx = 0;
  logic [31:0] rv;

  function automatic logic [31:0] rb_word(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h9E37_79B1);
  endfunction

  assign cp_rdata = rb_word(src_idx);

  always @(negedge clk) begin
    cp_wready <= (wmode == 0) ? 1'b1 : (wmode == 1) ? 1'($urandom % 2) : 1'b0;
    cp_rvalid <= (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'($urandom % 2) : 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && cp_wvalid && cp_wready) begin
      sink_mem[sink_n] <= cp_wdata;
      sink_n <= sink_n + 1;
    end
    if (rst_n && cp_rvalid && cp_rready) src_idx <= src_idx + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 7'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push_word(input logic [31:0] d);
    bus_write(64, d);
    exp_mem[exp_n] = d;
    exp_n++;
  endtask

  task automatic wait_ctrl(input int bitn, input string req);
    logic [31:0] v;
    int tries = 0;
    do begin
      bus_read(67, v);
      tries++;
    end while (v[bitn] && tries < 3000);
    check(!v[bitn], req, v, 32'h0);
  endtask

  task automatic compare_sink(input int from, input string req);
    repeat (2) @(negedge clk);
    check(sink_n == exp_n, req, 32'(sink_n), 32'(exp_n));
    for (int i = from; i < exp_n; i++)
      if (sink_mem[i] !== exp_mem[i]) check(0, req, sink_mem[i], exp_mem[i]);
    n_checks++;
  endtask

  task automatic pop_and_compare(input int n, input string req);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      bus_read(65, v);
      check(v === rb_word(pop_idx), req, v, rb_word(pop_idx));
      pop_idx++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    bus_read(69, rv); check(rv == 64, "R1 vacancy", rv, 64);
    bus_read(70, rv); check(rv == 0, "R1 occupancy", rv, 0);
    bus_read(67, rv); check(rv == 0, "R1 control", rv, 0);
    bus_read(8, rv);  check(rv == 0, "R1 isr", rv, 0);
    bus_read(68, rv); check((rv & 5) == 5, "R7 idle status", rv, 5);

    // R2 R3 R4 drain with random ready
    wmode = 1;
    base = exp_n;
    for (int i = 0; i < 10; i++) push_word($urandom);
    bus_read(69, rv); check(rv == 54, "R2 vacancy", rv, 54);
    bus_write(67, 1);
    bus_read(67, rv); check(rv[0] == 1'b1, "R3 busy", rv, 1);
    wait_ctrl(0, "R3 self clear");
    compare_sink(base, "R2 order");
    bus_read(8, rv); check(rv[0] == 1'b1, "R9 write done", rv, 1);

    // R10 interrupt gating
    bus_write(10, 1); check(irq == 1'b0, "R10 gie off", 32'(irq), 0);
    bus_write(7, 1);  check(irq == 1'b1, "R10 enabled", 32'(irq), 1);
    bus_write(10, 0); check(irq == 1'b0, "R10 ier off", 32'(irq), 0);
    bus_write(10, 1);
    bus_write(8, 1);  check(irq == 1'b0, "R10 after clear", 32'(irq), 0);
    bus_read(8, rv);  check(rv == 0, "R9 w1c", rv, 0);

    // R8 overflow and R4 hold while not ready
    wmode = 2;
    base = exp_n;
    for (int i = 0; i < DEPTH; i++) push_word(32'hA500_0000 + 32'(i));
    bus_read(69, rv); check(rv == 0, "R2 vacancy full", rv, 0);
    bus_read(68, rv); check(rv[2] == 1'b0, "R7 queue not empty", rv, 0);
    bus_write(64, 32'hDEAD_BEEF);
    bus_read(71, rv); check(rv == 1, "R8 overflow flag", rv, 1);
    bus_read(69, rv); check(rv == 0, "R8 no extra word", rv, 0);
    bus_write(67, 1);
    repeat (10) @(negedge clk);
    bus_read(67, rv); check(rv[0] == 1'b1, "R4 stalled busy", rv, 1);
    check(sink_n == base, "R4 nothing sent", 32'(sink_n), 32'(base));
    wmode = 0;
    wait_ctrl(0, "R3 drain full");
    compare_sink(base, "R8 dropped word absent");
    bus_read(71, rv); check(rv == 1, "R8 sticky", rv, 1);
    bus_write(71, 1);
    bus_read(71, rv); check(rv == 0, "R8 cleared", rv, 0);

    // R5 R6 readback
    rmode = 1;
    bus_write(66, 5);
    bus_read(66, rv); check(rv == 5, "R5 size", rv, 5);
    bus_write(67, 2);
    wait_ctrl(1, "R5 self clear");
    bus_read(70, rv); check(rv == 5, "R5 occupancy", rv, 5);
    pop_and_compare(5, "R6 pop data");
    bus_read(70, rv); check(rv == 0, "R6 drained", rv, 0);
    bus_read(65, rv); check(rv == 0, "R6 empty read", rv, 0);
    bus_read(8, rv);  check(rv[1] == 1'b1, "R9 read done", rv, 2);

    // R12 read queue full stalls readback
    rmode = 0;
    bus_write(66, 66);
    bus_write(67, 2);
    repeat (200) @(negedge clk);
    bus_read(70, rv); check(rv == 64, "R12 full", rv, 64);
    bus_read(67, rv); check(rv[1] == 1'b1, "R12 still busy", rv, 2);
    pop_and_compare(64, "R12 data");
    wait_ctrl(1, "R12 resume");
    bus_read(70, rv); check(rv == 2, "R12 remainder", rv, 2);
    pop_and_compare(2, "R12 tail");

    // R11 reserved offsets
    bus_write(9, 32'hFFFF_FFFF);
    bus_write(100, 32'hFFFF_FFFF);
    bus_read(9, rv);   check(rv == 0, "R11 read 9", rv, 0);
    bus_read(100, rv); check(rv == 0, "R11 read 100", rv, 0);
    bus_read(7, rv);   check(rv == 1, "R11 gie kept", rv, 1);
    bus_read(10, rv);  check(rv == 1, "R11 ier kept", rv, 1);

    // Random rounds of drain traffic
    for (int r = 0; r < 6; r++) begin
      int n;
      n = $urandom_range(1, 20);
      wmode = 2;
      base = exp_n;
      for (int i = 0; i < n; i++) push_word($urandom);
      bus_read(69, rv); check(rv == 32'(DEPTH - n), "R2 random vacancy", rv, 32'(DEPTH - n));
      wmode = 1;
      bus_write(67, 1);
      wait_ctrl(0, "R3 random drain");
      compare_sink(base, "R2 random order");
    end

    finished = 1;
    summary();
  end
endmodule